// File: doc/BRIEF.md
# Bus Clock Source Mode Controller

This block is the control logic that chooses where the bus clock comes from. It can take the bus clock from the PLL output or from the external oscillator, once that oscillator has been qualified. Software sets an oscillator enable, a filter enable, a filter bandwidth bit, a 5-bit filter value and a source-select bit through a small register write port. Hardware watches the PLL lock and the oscillator-ready inputs. Both inputs are synchronized into the bus clock domain before use. The analog PLL, the oscillator, the spike filter and the glitch-free clock multiplexer are outside this block. It drives them only through select and enable outputs.

A three-state machine holds the clock choice. `ST_PLL_DIV4` means the PLL source is selected while the PLL is unlocked, so the PLL clock is the VCO divided by four. `ST_PLL_LOCKED` means the PLL source is selected and the PLL is locked. `ST_OSC` means the oscillator source is selected.

The transitions are:
- `T_LOCK`: DIV4 to LOCKED when the synchronized lock rises.
- `T_UNLOCK`: LOCKED to DIV4 when the synchronized lock falls.
- `T_TO_OSC`: either PLL state to OSC when software writes select 0 while the oscillator is qualified.
- `T_SW_BACK`: OSC to a PLL state when software writes select 1.
- `T_FALLBACK`: OSC to a PLL state when qualification is lost. This transition also sets a sticky loss flag.

The PLL state entered from OSC is LOCKED or DIV4, depending on the current lock level. When the filter is enabled, a lock drop removes qualification at once and so forces `T_FALLBACK`.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, src_sel=1, pll_div4=1, osc_en=0, filt_en=0, filt_bw=0, filt_val=0, flags=0 and irq=0.
- R2: A write to address 0 carries src_sel in bit 0, where 1 selects the PLL and 0 selects the oscillator. A write of 0 is ignored unless oscq_sts is 1 in that cycle.
- R3: oscq_sts is 1 only when osc_en=1 and the synchronized oscillator-ready level is 1. While filt_en=1, oscq_sts also needs lock_sts=1, so a lock drop clears oscq_sts in the same cycle that lock_sts falls.
- R4: If oscq_sts is 0 while src_sel=0, src_sel becomes 1 on the next clock edge and flag bit 2 (oscillator loss) is set.
- R5: pll_div4 is 1 exactly while lock_sts is 0, whatever the selected source.
- R6: Address 0 holds osc_en in bit 1, filt_en in bit 2 and filt_bw in bit 3. Address 1 bits 4:0 hold filt_val. All of these are driven out unchanged.
- R7: pll_lock_raw and osc_ready_raw each pass through two flip-flops. A raw change shows on lock_sts, or affects oscq_sts, after the second clock edge.
- R8: Flag bit 0 sets on any change of lock_sts and flag bit 1 sets on any change of oscq_sts. Flags are sticky, and writing 1 to a bit at address 2 clears it. A set in the same cycle wins over a clear.
- R9: Address 2 is the flag register. Address 3 bits 2:0 enable each flag for the interrupt. irq is the OR of the flags that are both set and enabled.
- R10: In ST_OSC, a software write of src_sel=1 returns to the PLL and does not set flag bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock_raw | input | 1 | Unsynchronized PLL lock indication |
| osc_ready_raw | input | 1 | Unsynchronized oscillator started, and filtered-qualified when the filter is on |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 filter value, 2 flags, 3 interrupt enables |
| wr_data | input | 5 | Register write data |
| src_sel | output | 1 | 1 = bus clock from PLL, 0 = from oscillator |
| pll_div4 | output | 1 | PLL clock uses the divide-by-four path |
| osc_en | output | 1 | Oscillator enable |
| filt_en | output | 1 | Spike filter enable |
| filt_bw | output | 1 | Filter bandwidth select |
| filt_val | output | 5 | Filter integer setting |
| lock_sts | output | 1 | Synchronized lock status |
| oscq_sts | output | 1 | Oscillator-qualified status |
| flags | output | 3 | Sticky flags: bit 0 lock change, bit 1 qualification change, bit 2 oscillator loss |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check four things on every cycle. The oscillator source is left on the edge after qualification is lost. A move onto the oscillator happens only if qualification held in the deciding cycle. The loss flag rises only out of the oscillator state. A set flag stays set unless a clear is written. Only the directed scenarios show the rest:
- the two-edge synchronizer latency;
- the dependence of qualification on lock, with and without the filter;
- priority between W1C clears and new sets;
- interrupt masking;
- the fact that a software return to the PLL leaves the loss flag clear.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

    typedef enum logic [1:0] {
        ST_PLL_DIV4   = 2'd0,
        ST_PLL_LOCKED = 2'd1,
        ST_OSC        = 2'd2
    } src_state_t;

    localparam int ADDR_W = 2;
    localparam int FLAG_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FILT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd3;

    localparam int CTRL_SRC  = 0;
    localparam int CTRL_OSCE = 1;
    localparam int CTRL_FEN  = 2;
    localparam int CTRL_FBW  = 3;

    localparam int FLG_LOCK = 0;
    localparam int FLG_OSCQ = 1;
    localparam int FLG_LOSS = 2;

endpackage

// File: rtl/clk_src_sync.sv
module clk_src_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_raw,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d_raw;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/clk_src_flags.sv
module clk_src_flags #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic [NFLAG-1:0] clr_vec,
    input  logic             ien_we,
    input  logic [NFLAG-1:0] ien_data,
    output logic [NFLAG-1:0] flags_q,
    output logic             irq
);
    logic [NFLAG-1:0] ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (ien_we) begin
            ien_q <= ien_data;
        end
    end

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags_q[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    flags_q[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    flags_q[i] <= 1'b0;
                end
            end

            // R8: a set flag stays set unless software clears it
            p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);
        end
    endgenerate

    assign irq = |(flags_q & ien_q);
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int FILT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_lock_raw,
    input  logic              osc_ready_raw,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [FILT_W-1:0] wr_data,
    output logic              src_sel,
    output logic              pll_div4,
    output logic              osc_en,
    output logic              filt_en,
    output logic              filt_bw,
    output logic [FILT_W-1:0] filt_val,
    output logic              lock_sts,
    output logic              oscq_sts,
    output logic [2:0]        flags,
    output logic              irq
);
    localparam int DATA_W = FILT_W;

    src_state_t state_q, state_d;
    logic [1:0] raw_vec, sync_vec;
    logic       lock_s, rdy_s;
    logic       lock_d, oscq_d;
    logic       wr_ctrl, wr_filt, wr_flag, wr_ien;
    logic       fallback;
    logic [FLAG_W-1:0] set_vec, clr_vec;

    // Two-flop synchronizer for both raw status inputs (R7)
    assign raw_vec = {osc_ready_raw, pll_lock_raw};

    clk_src_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_raw  (raw_vec),
        .q_sync (sync_vec)
    );

    assign lock_s = sync_vec[0];
    assign rdy_s  = sync_vec[1];

    // Register decode
    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_filt = wr_en && (wr_addr == ADDR_FILT);
    assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);
    assign wr_ien  = wr_en && (wr_addr == ADDR_IEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_en   <= 1'b0;
            filt_en  <= 1'b0;
            filt_bw  <= 1'b0;
            filt_val <= '0;
        end else begin
            if (wr_ctrl) begin
                osc_en  <= wr_data[CTRL_OSCE];
                filt_en <= wr_data[CTRL_FEN];
                filt_bw <= wr_data[CTRL_FBW];
            end
            if (wr_filt) begin
                filt_val <= wr_data[FILT_W-1:0];
            end
        end
    end

    // Qualification: filtered mode relies on the PLL clock, so it needs lock
    assign oscq_sts = osc_en && rdy_s && (!filt_en || lock_s);
    assign lock_sts = lock_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PLL_DIV4;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        fallback = 1'b0;
        unique case (state_q)
            ST_PLL_DIV4: begin
                if (wr_ctrl && !wr_data[CTRL_SRC] && oscq_sts) begin
                    state_d = ST_OSC;                       // T_TO_OSC
                end else if (lock_s) begin
                    state_d = ST_PLL_LOCKED;                // T_LOCK
                end
            end
            ST_PLL_LOCKED: begin
                if (wr_ctrl && !wr_data[CTRL_SRC] && oscq_sts) begin
                    state_d = ST_OSC;                       // T_TO_OSC
                end else if (!lock_s) begin
                    state_d = ST_PLL_DIV4;                  // T_UNLOCK
                end
            end
            ST_OSC: begin
                if (!oscq_sts) begin
                    fallback = 1'b1;                        // T_FALLBACK
                    state_d  = lock_s ? ST_PLL_LOCKED : ST_PLL_DIV4;
                end else if (wr_ctrl && wr_data[CTRL_SRC]) begin
                    state_d  = lock_s ? ST_PLL_LOCKED : ST_PLL_DIV4;  // T_SW_BACK
                end
            end
            default: state_d = ST_PLL_DIV4;
        endcase
    end

    // Outputs
    always_comb begin
        src_sel  = (state_q != ST_OSC);
        pll_div4 = !lock_s;
    end

    // Change detection for the sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_d <= 1'b0;
            oscq_d <= 1'b0;
        end else begin
            lock_d <= lock_s;
            oscq_d <= oscq_sts;
        end
    end

    always_comb begin
        set_vec           = '0;
        set_vec[FLG_LOCK] = lock_s ^ lock_d;
        set_vec[FLG_OSCQ] = oscq_sts ^ oscq_d;
        set_vec[FLG_LOSS] = fallback;
        clr_vec           = wr_flag ? wr_data[FLAG_W-1:0] : '0;
    end

    clk_src_flags #(.NFLAG(FLAG_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .ien_we   (wr_ien),
        .ien_data (wr_data[FLAG_W-1:0]),
        .flags_q  (flags),
        .irq      (irq)
    );

    // R4: losing qualification on the oscillator forces the PLL next cycle
    p_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel && !oscq_sts) |=> src_sel);

    // R2: the oscillator is only entered when qualification held
    p_enter_osc_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(src_sel) |-> $past(oscq_sts));

    // R4: the loss flag only rises when leaving the oscillator source
    p_loss_from_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_LOSS]) |-> ($past(!src_sel) && src_sel));

    initial begin
        assert (DATA_W >= FLAG_W) else $error("data width too narrow");
    end
endmodule

// File: tb/clk_src_ctrl_tb_top.sv
module clk_src_ctrl_tb_top;
    localparam int FW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_lock_raw = 1'b0;
    logic          osc_ready_raw = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [FW-1:0] wr_data = '0;
    logic          src_sel, pll_div4, osc_en, filt_en, filt_bw;
    logic [FW-1:0] filt_val;
    logic          lock_sts, oscq_sts, irq;
    logic [2:0]    flags;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    clk_src_ctrl #(.FILT_W(FW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pll_lock_raw  (pll_lock_raw),
        .osc_ready_raw (osc_ready_raw),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .src_sel       (src_sel),
        .pll_div4      (pll_div4),
        .osc_en        (osc_en),
        .filt_en       (filt_en),
        .filt_bw       (filt_bw),
        .filt_val      (filt_val),
        .lock_sts      (lock_sts),
        .oscq_sts      (oscq_sts),
        .flags         (flags),
        .irq           (irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [FW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset;
        chk("R1 src_sel", src_sel, 1);
        chk("R1 pll_div4", pll_div4, 1);
        chk("R1 osc_en", osc_en, 0);
        chk("R1 filt_en", filt_en, 0);
        chk("R1 filt_bw", filt_bw, 0);
        chk("R1 filt_val", filt_val, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_sync_lock;
        pll_lock_raw = 1'b1;
        tick(1);
        chk("R7 lock after one edge", lock_sts, 0);
        tick(1);
        chk("R7 lock after two edges", lock_sts, 1);
        chk("R5 div4 off when locked", pll_div4, 0);
        tick(1);
        chk("R8 lock change flag", flags, 3'b001);
    endtask

    task automatic t_ignore_unqualified;
        wr(2'd0, 5'b00000);
        chk("R2 write 0 ignored unqualified", src_sel, 1);
        chk("R2 oscq low", oscq_sts, 0);
    endtask

    task automatic t_enter_osc;
        wr(2'd0, 5'b00111);                 // src=1, osc_en, filt_en
        osc_ready_raw = 1'b1;
        tick(3);
        chk("R3 qualified with filter and lock", oscq_sts, 1);
        wr(2'd2, 5'b00111);
        chk("R8 W1C clears all", flags, 0);
        wr(2'd0, 5'b00110);
        chk("R2 write 0 accepted when qualified", src_sel, 0);
        wr(2'd3, 5'b00100);
        chk("R9 irq quiet", irq, 0);
    endtask

    task automatic t_lock_loss_fallback;
        pll_lock_raw = 1'b0;
        tick(2);
        chk("R3 filtered lock drop clears oscq", oscq_sts, 0);
        chk("R3 lock_sts low", lock_sts, 0);
        chk("R4 still on osc before edge", src_sel, 0);
        tick(1);
        chk("R4 fallback to PLL", src_sel, 1);
        chk("R4 loss flag with change flags", flags, 3'b111);
        chk("R5 div4 while unlocked", pll_div4, 1);
        chk("R9 irq from loss flag", irq, 1);
        wr(2'd2, 5'b00100);
        chk("R8 clear only bit 2", flags, 3'b011);
        chk("R9 irq masked", irq, 0);
        wr(2'd3, 5'b00001);
        chk("R9 irq via lock flag", irq, 1);
    endtask

    task automatic t_sw_back;
        pll_lock_raw = 1'b1;
        tick(3);
        chk("R3 requalified after relock", oscq_sts, 1);
        wr(2'd2, 5'b00111);
        chk("R8 flags cleared", flags, 0);
        wr(2'd0, 5'b00110);
        chk("R2 back on osc", src_sel, 0);
        wr(2'd0, 5'b00111);
        chk("R10 software return to PLL", src_sel, 1);
        tick(1);
        chk("R10 no loss flag", flags, 0);
    endtask

    task automatic t_filter_fields;
        wr(2'd1, 5'h15);
        chk("R6 filt_val", filt_val, 5'h15);
        wr(2'd0, 5'b01111);
        chk("R6 filt_bw", filt_bw, 1);
        chk("R6 filt_en", filt_en, 1);
        chk("R6 osc_en", osc_en, 1);
        chk("R2 src stays PLL", src_sel, 1);
    endtask

    task automatic t_unfiltered;
        wr(2'd0, 5'b00011);                 // filter off, osc on
        pll_lock_raw = 1'b0;
        tick(3);
        chk("R3 unfiltered oscq survives lock loss", oscq_sts, 1);
        chk("R5 div4 on unlock", pll_div4, 1);
        wr(2'd0, 5'b00010);
        chk("R2 enter osc while unlocked", src_sel, 0);
        wr(2'd2, 5'b00111);
        wr(2'd0, 5'b00000);                 // disable oscillator
        chk("R3 osc_en off clears oscq", oscq_sts, 0);
        chk("R4 src not yet switched", src_sel, 0);
        tick(1);
        chk("R4 fallback on disable", src_sel, 1);
        chk("R4 loss flag set", flags[2], 1);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        t_reset;
        rst_n = 1'b1;
        tick(1);
        t_reset;
        t_sync_lock;
        t_ignore_unqualified;
        t_enter_osc;
        t_lock_loss_fallback;
        t_sw_back;
        t_filter_fields;
        t_unfiltered;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule